// File: doc/BRIEF.md
# Shared Semaphore Token Unit

This block holds a small bank of single-bit ownership tokens that two independent ports, called left and right, share. Software on either side uses a token to mark a shared resource as taken. To reach the token space, a port drives its select strobe low and its chip enable high. It then names a token with an index. A write with the write bit at 0 asks for the token. A write with the write bit at 1 gives the token back.

A refused request is not lost. It stays latched as pending for that port. When the holder gives the token back, the pending port receives it automatically in the following cycle. If both ports ask for a free token in the same cycle, the left port wins and the right request waits. A read tells the port whether it currently holds the named token.

All state changes on the rising clock edge. Read data depends combinationally on the registered state and on the read inputs presented in the same cycle.

Top module: `sem_token_unit`

## Requirements
- R1: After reset every token is free: a read of any index from either port returns all ones.
- R2: At no time do both ports hold the same token.
- R3: A port reaches the token space only when its select strobe is 0 and its chip enable is 1. Otherwise its writes change nothing and its read data is all ones.
- R4: A request (write bit 0) to a free token grants it at the next clock edge. From then on the owner reads all zeros and the other port reads all ones.
- R5: A request to a token held by the other port is refused. The holder keeps the token and the requester reads all ones.
- R6: A refused request stays pending. When the holder releases (write bit 1), the pending port holds the token after that same clock edge.
- R7: When both ports request a free token in the same cycle, the left port is granted and the right request stays pending. The right port is granted when the left port releases.
- R8: A release from a port that does not hold the token has no effect. A repeat request while one is already pending has no effect, so a single release by that port afterwards frees the token.
- R9: An operation on one index leaves every other token unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| l_sel_n | input | 1 | Left token-space select, active low |
| l_ce | input | 1 | Left chip enable, active high |
| l_we | input | 1 | Left write (1) or read (0) |
| l_idx | input | IDX_W (3) | Left token index |
| l_wbit | input | 1 | Left write bit: 0 request, 1 release |
| l_rdata | output | DATA_W (8) | Left status: all zeros when left holds the token, all ones otherwise |
| r_sel_n | input | 1 | Right token-space select, active low |
| r_ce | input | 1 | Right chip enable, active high |
| r_we | input | 1 | Right write (1) or read (0) |
| r_idx | input | IDX_W (3) | Right token index |
| r_wbit | input | 1 | Right write bit: 0 request, 1 release |
| r_rdata | output | DATA_W (8) | Right status: all zeros when right holds the token, all ones otherwise |

## Verification
The main function is exercised with several patterns, and each one separates a different failure:
- A lone request on a free token shows that plain granting works.
- A request against a held token shows that the holder is protected and that the request is kept as pending.
- A release with a request waiting shows the automatic handoff.
- Equal-cycle requests from both ports show the left-first tie rule.
- Releases by the non-holder, and repeated requests, show that stray writes neither steal a token nor stack up.

Operations on different indices are interleaved to catch cross-talk between tokens. Writes made with the strobe or the chip enable inactive are checked to have no effect.

// File: rtl/sem_pkg.sv
package sem_pkg;
   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_REQ  = 2'd1,
      OP_REL  = 2'd2
   } sem_op_e;

   typedef struct packed {
      logic own;
      logic pend;
   } side_t;

   localparam side_t SIDE_IDLE = '{own: 1'b0, pend: 1'b0};
endpackage

// File: rtl/sem_port_if.sv
module sem_port_if #(
   parameter int NUM_SEM = 8,
   parameter int DATA_W  = 8,
   parameter int IDX_W   = $clog2(NUM_SEM)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sel_n,
   input  logic               ce,
   input  logic               we,
   input  logic [IDX_W-1:0]   idx,
   input  logic               wbit,
   input  logic [NUM_SEM-1:0] owned,
   output logic [NUM_SEM-1:0] req,
   output logic [NUM_SEM-1:0] rel,
   output logic [DATA_W-1:0]  rdata
);
   logic active;
   logic wr_act;
   logic rd_own;

   assign active = !sel_n && ce;
   assign wr_act = active && we;

   for (genvar i = 0; i < NUM_SEM; i++) begin : g_dec
      assign req[i] = wr_act && (idx == IDX_W'(i)) && !wbit;
      assign rel[i] = wr_act && (idx == IDX_W'(i)) && wbit;
   end

   always_comb begin
      rd_own = 1'b0;
      if (active && !we && (int'(idx) < NUM_SEM))
         rd_own = owned[idx];
   end

   assign rdata = rd_own ? '0 : '1;

   AST_IDLE_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_n || !ce) |-> (rdata == '1)); // R3
   AST_ONE_TOKEN_TOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req | rel)); // R9
endmodule

// File: rtl/sem_cell.sv
module sem_cell
   import sem_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_l,
   input  logic rel_l,
   input  logic req_r,
   input  logic rel_r,
   output logic own_l,
   output logic own_r
);
   side_t lq, rq;
   side_t ld, rd;
   logic  l_kept, r_kept, l_want, r_want, free_n, gnt_l, gnt_r;

   always_comb begin
      l_kept = lq.own && !rel_l;
      r_kept = rq.own && !rel_r;
      l_want = lq.pend || (req_l && !lq.own);
      r_want = rq.pend || (req_r && !rq.own);
      free_n = !l_kept && !r_kept;
      gnt_l  = free_n && l_want;
      gnt_r  = free_n && !l_want && r_want;
      ld.own  = l_kept || gnt_l;
      ld.pend = l_want && !gnt_l;
      rd.own  = r_kept || gnt_r;
      rd.pend = r_want && !gnt_r;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lq <= SIDE_IDLE;
         rq <= SIDE_IDLE;
      end else begin
         lq <= ld;
         rq <= rd;
      end
   end

   assign own_l = lq.own;
   assign own_r = rq.own;

   AST_SINGLE_HOLDER: assert property (@(posedge clk) disable iff (!rst_n)
      !(own_l && own_r)); // R2
   AST_FREE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (!own_l && !own_r && req_l) |=> own_l); // R4
   AST_DENY_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      (own_l && !rel_l && req_r) |=> (own_l && !own_r)); // R5
   AST_HANDOFF_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
      (own_r && rel_r && lq.pend) |=> own_l); // R6
   AST_TIE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
      (!own_l && !own_r && req_l && req_r) |=> (own_l && rq.pend)); // R7
endmodule

// File: rtl/sem_token_unit.sv
module sem_token_unit #(
   parameter int NUM_SEM = 8,
   parameter int DATA_W  = 8,
   parameter int IDX_W   = $clog2(NUM_SEM)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_sel_n,
   input  logic              l_ce,
   input  logic              l_we,
   input  logic [IDX_W-1:0]  l_idx,
   input  logic              l_wbit,
   output logic [DATA_W-1:0] l_rdata,
   input  logic              r_sel_n,
   input  logic              r_ce,
   input  logic              r_we,
   input  logic [IDX_W-1:0]  r_idx,
   input  logic              r_wbit,
   output logic [DATA_W-1:0] r_rdata
);
   if (NUM_SEM < 2) begin : g_chk_num
      $error("NUM_SEM must be at least 2");
   end
   if (DATA_W < 1) begin : g_chk_w
      $error("DATA_W must be at least 1");
   end
   if ((1 << IDX_W) < NUM_SEM) begin : g_chk_idx
      $error("IDX_W too narrow for NUM_SEM");
   end

   logic [NUM_SEM-1:0] l_req, l_rel, r_req, r_rel, l_own, r_own;

   sem_port_if #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_lport (
      .clk(clk), .rst_n(rst_n), .sel_n(l_sel_n), .ce(l_ce), .we(l_we),
      .idx(l_idx), .wbit(l_wbit), .owned(l_own), .req(l_req), .rel(l_rel),
      .rdata(l_rdata));

   sem_port_if #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_rport (
      .clk(clk), .rst_n(rst_n), .sel_n(r_sel_n), .ce(r_ce), .we(r_we),
      .idx(r_idx), .wbit(r_wbit), .owned(r_own), .req(r_req), .rel(r_rel),
      .rdata(r_rdata));

   for (genvar i = 0; i < NUM_SEM; i++) begin : g_cell
      sem_cell u_cell (
         .clk(clk), .rst_n(rst_n),
         .req_l(l_req[i]), .rel_l(l_rel[i]),
         .req_r(r_req[i]), .rel_r(r_rel[i]),
         .own_l(l_own[i]), .own_r(r_own[i]));
   end
endmodule

// File: tb/sem_token_unit_test.sv
`timescale 1ns/1ps
module sem_token_unit_test;
   localparam int NS = 8;
   localparam int DW = 8;
   localparam int IW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic l_sel_n, l_ce, l_we, l_wbit, r_sel_n, r_ce, r_we, r_wbit;
   logic [IW-1:0] l_idx, r_idx;
   logic [DW-1:0] l_rdata, r_rdata;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   sem_token_unit #(.NUM_SEM(NS), .DATA_W(DW), .IDX_W(IW)) uut (
      .clk(clk), .rst_n(rst_n),
      .l_sel_n(l_sel_n), .l_ce(l_ce), .l_we(l_we), .l_idx(l_idx),
      .l_wbit(l_wbit), .l_rdata(l_rdata),
      .r_sel_n(r_sel_n), .r_ce(r_ce), .r_we(r_we), .r_idx(r_idx),
      .r_wbit(r_wbit), .r_rdata(r_rdata));

   // row: {lop[2], lidx[3], rop[2], ridx[3], chk[3], own[2], req[4]}
   // op: 0 idle, 1 request, 2 release; own: 0 free, 1 left, 2 right
   localparam int NV = 15;
   localparam logic [18:0] VEC [NV] = '{
      {2'd1,3'd3,2'd0,3'd0,3'd3,2'd1,4'd4}, // R4 left takes 3
      {2'd0,3'd0,2'd1,3'd3,3'd3,2'd1,4'd5}, // R5 right refused
      {2'd0,3'd0,2'd1,3'd3,3'd3,2'd1,4'd8}, // R8 repeat request
      {2'd2,3'd3,2'd0,3'd0,3'd3,2'd2,4'd6}, // R6 handoff to right
      {2'd0,3'd0,2'd2,3'd3,3'd3,2'd0,4'd8}, // R8 one release frees
      {2'd1,3'd5,2'd1,3'd5,3'd5,2'd1,4'd7}, // R7 tie -> left
      {2'd2,3'd5,2'd0,3'd0,3'd5,2'd2,4'd7}, // R7 right pending granted
      {2'd2,3'd5,2'd0,3'd0,3'd5,2'd2,4'd8}, // R8 non-holder release
      {2'd0,3'd0,2'd2,3'd5,3'd5,2'd0,4'd4}, // R4 free again
      {2'd0,3'd0,2'd1,3'd0,3'd0,2'd2,4'd4}, // R4 right takes 0
      {2'd1,3'd7,2'd0,3'd0,3'd0,2'd2,4'd9}, // R9 index 0 untouched
      {2'd0,3'd0,2'd0,3'd0,3'd7,2'd1,4'd9}, // R9 index 7 left
      {2'd2,3'd7,2'd2,3'd0,3'd0,2'd0,4'd9}, // R9 both released
      {2'd0,3'd0,2'd2,3'd2,3'd2,2'd0,4'd8}, // R8 release of free token
      {2'd0,3'd0,2'd0,3'd0,3'd7,2'd0,4'd2}  // R2 final state free
   };

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle_all();
      l_sel_n = 1'b1; l_ce = 1'b0; l_we = 1'b0; l_idx = '0; l_wbit = 1'b1;
      r_sel_n = 1'b1; r_ce = 1'b0; r_we = 1'b0; r_idx = '0; r_wbit = 1'b1;
   endtask

   task automatic drive(input logic [1:0] lop, input logic [2:0] li,
                        input logic [1:0] rop, input logic [2:0] ri);
      @(negedge clk);
      idle_all();
      if (lop != 2'd0) begin
         l_sel_n = 1'b0; l_ce = 1'b1; l_we = 1'b1; l_idx = li; l_wbit = (lop == 2'd2);
      end
      if (rop != 2'd0) begin
         r_sel_n = 1'b0; r_ce = 1'b1; r_we = 1'b1; r_idx = ri; r_wbit = (rop == 2'd2);
      end
   endtask

   task automatic read_both(input logic [2:0] i, input logic [1:0] own, input string tag);
      @(negedge clk);
      idle_all();
      l_sel_n = 1'b0; l_ce = 1'b1; l_idx = i;
      r_sel_n = 1'b0; r_ce = 1'b1; r_idx = i;
      #1;
      chk({tag, " left"},  l_rdata, (own == 2'd1) ? '0 : '1);
      chk({tag, " right"}, r_rdata, (own == 2'd2) ? '0 : '1);
   endtask

   initial begin
      #100000;
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      idle_all();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: every token free after reset
      for (int i = 0; i < NS; i++) read_both(3'(i), 2'd0, "R1 reset");

      for (int v = 0; v < NV; v++) begin
         drive(VEC[v][18:17], VEC[v][16:14], VEC[v][13:12], VEC[v][11:9]);
         read_both(VEC[v][8:6], VEC[v][5:4], $sformatf("R%0d row%0d", VEC[v][3:0], v));
      end

      // R3: strobe inactive -> write ignored
      @(negedge clk);
      idle_all();
      l_sel_n = 1'b1; l_ce = 1'b1; l_we = 1'b1; l_idx = 3'd1; l_wbit = 1'b0;
      read_both(3'd1, 2'd0, "R3 sel_n high");
      // R3: chip enable low -> write ignored
      @(negedge clk);
      idle_all();
      r_sel_n = 1'b0; r_ce = 1'b0; r_we = 1'b1; r_idx = 3'd1; r_wbit = 1'b0;
      read_both(3'd1, 2'd0, "R3 ce low");
      // R3: owner reads ones when not selected
      drive(2'd1, 3'd4, 2'd0, 3'd0);
      read_both(3'd4, 2'd1, "R3 owner");
      @(negedge clk);
      idle_all();
      l_sel_n = 1'b1; l_ce = 1'b1; l_idx = 3'd4;
      #1;
      chk("R3 unselected read", l_rdata, '1);

      // R8: release by non-holder does not cancel a pending request
      drive(2'd0, 3'd0, 2'd1, 3'd4);
      drive(2'd0, 3'd0, 2'd2, 3'd4);
      drive(2'd2, 3'd4, 2'd0, 3'd0);
      read_both(3'd4, 2'd2, "R8 pending kept");

      // R1: reset clears held token
      @(negedge clk);
      idle_all();
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      read_both(3'd4, 2'd0, "R1 re-reset");

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule